// File: doc/BRIEF.md
# Two-Mode Banked ROM/RAM Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and a pair of external memories: a banked ROM of up to 2 MB and a banked RAM of up to 32 KB. Stores that fall in the lower 32 KB of the CPU map do not reach the ROM. They are decoded as writes to four control registers: a RAM enable, a 5-bit primary bank number, a 2-bit secondary bank number and a mode bit. Every read is translated with no added latency. A read of the ROM half gives a 21-bit physical ROM address. A read of the 8 KB RAM window gives a 15-bit RAM address and a RAM select. Every other read returns a forced 0xFF.

The ROM bank count and the RAM size are set on configuration inputs, which the block samples only while reset is held. The secondary register serves several purposes. On large ROMs it always supplies the upper bits of the switchable-window bank. In mode 1 it also moves the fixed lower window to a higher bank. On a 32 KB RAM in mode 1 it picks the RAM page. The primary register is masked to the configured bank count at the moment it is written. The storage arrays themselves sit outside the block.

Top module: `bank_mapper`

## Requirements
- R1: A write with address bits 15:13 = 000 sets the RAM enable when data bits 3:0 equal 0xA and clears it for any other value. The upper data nibble is ignored.
- R2: A write with address bits 15:13 = 001 loads the primary bank register. If data bits 4:0 are zero, the register becomes 1. Otherwise it becomes the data ANDed with a mask set by the ROM code: code 0 (2 banks) 0x01, code 1 (4) 0x03, code 2 (8) 0x07, code 3 (16) 0x0F, codes 4 and above 0x1F.
- R3: A write with address bits 15:13 = 010 loads the secondary register from data bits 1:0. A write with bits 15:13 = 011 loads the mode bit from data bit 0. With no write, the control registers keep their values.
- R4: For a read of 0x0000–0x3FFF, rom_addr = bank × 0x4000 + (addr & 0x3FFF). The bank is 0 in mode 0. In mode 1 the bank is secondary[0] × 32 for ROM code 5 (64 banks), secondary × 32 for code 6 (128 banks), and 0 for codes 0–4.
- R5: For a read of 0x4000–0x7FFF, rom_addr = bank × 0x4000 + (addr & 0x3FFF), in either mode. The bank is the primary register, plus secondary[0] × 32 for code 5 or secondary × 32 for code 6. A write to the control registers changes the translation only from the next cycle.
- R6: RAM code cfg_ram_size is 0 = none, 1 = 2 KB, 2 = 8 KB, 3 = 32 KB. Take off = addr − 0xA000 for the window 0xA000–0xBFFF. On a 32 KB RAM in mode 1, ram_addr = secondary × 0x2000 + off. On a 32 KB RAM in mode 0, and on an 8 KB RAM, ram_addr = off. On a 2 KB RAM, ram_addr = off mod 0x800.
- R7: bus_rdata is 0xFF when the RAM window is read with RAM disabled or with no RAM configured. It is also 0xFF for any address in neither the ROM half nor the RAM window. In these cases ram_sel is low.
- R8: A reset sets the primary register to 1 and the secondary register, the mode bit and the RAM enable to 0. Both configuration inputs are sampled only while rst_n is low, so a later change to them has no effect. ROM code 7 is treated as code 6.
- R9: bus_rdata equals rom_rdata for addresses 0x0000–0x7FFF. It equals ram_rdata when ram_sel is high.
- R10: ram_sel is high exactly when the address is in the RAM window, RAM is enabled and a RAM is configured. ram_we is bus_wr ANDed with ram_sel, so control-register writes never assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration sampled while low |
| cfg_rom_size | input | 3 | ROM code n, 2^(n+1) banks of 16 KB |
| cfg_ram_size | input | 2 | RAM code: 0 none, 1 2 KB, 2 8 KB, 3 32 KB |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_sel | output | 1 | RAM access is valid this cycle |
| ram_we | output | 1 | Write strobe to the external RAM |
| ram_rdata | input | 8 | Data from the external RAM |

## Verification
A write to the secondary register also targets the switchable ROM window, since addresses 0x4000–0x5FFF lie inside it. In that one cycle a register update and an address translation therefore coincide. The bench holds such a write on a 128-bank or 64-bank configuration. It checks that rom_addr still carries the old upper bank bits before the clock edge and the new ones after it. The bench also asserts the write strobe at RAM-window addresses, both with RAM enabled and disabled. It judges whether ram_we follows the enable state that was current in that same cycle.

// File: rtl/bank_mapper_pkg.sv
// Shared constants and types for the banked ROM/RAM mapper.
// Assumes an 8-bit CPU bus with a 16-bit address and 16 KB ROM windows.
package bank_mapper_pkg;
    localparam int CPU_AW      = 16;
    localparam int CPU_DW      = 8;
    localparam int WIN_OFF_W   = 14;                    // offset inside a 16 KB ROM window
    localparam int PRIM_W      = 5;                     // primary bank register width
    localparam int SEC_W       = 2;                     // secondary register width
    localparam int ROM_BANK_W  = PRIM_W + SEC_W;        // up to 128 banks
    localparam int ROM_AW      = ROM_BANK_W + WIN_OFF_W;
    localparam int RAM_PAGE_W  = 13;                    // 8 KB RAM page
    localparam int RAM_AW      = RAM_PAGE_W + SEC_W;    // up to 32 KB
    localparam int SMALL_RAM_W = 11;                    // 2 KB RAM
    localparam int CODE_W      = 3;                     // ROM size code width
    localparam int CTL_DW      = PRIM_W;                // data bits seen by the control registers
    localparam logic [CODE_W-1:0] MAX_ROM_CODE = CODE_W'(ROM_BANK_W - 1);

    typedef enum logic [1:0] {
        RAM_NONE = 2'd0,
        RAM_2K   = 2'd1,
        RAM_8K   = 2'd2,
        RAM_32K  = 2'd3
    } ram_cfg_e;

    // Control register picked by address bits 14:13 of a low-half write.
    typedef enum logic [1:0] {
        CTL_ENABLE    = 2'd0,
        CTL_PRIMARY   = 2'd1,
        CTL_SECONDARY = 2'd2,
        CTL_MODE      = 2'd3
    } ctl_sel_e;

    typedef enum logic [1:0] {
        SRC_ROM,
        SRC_RAM,
        SRC_FILL
    } rd_src_e;

    typedef struct packed {
        logic              ram_en;
        logic              mode;
        logic [SEC_W-1:0]  sec;
        logic [PRIM_W-1:0] prim;
    } bank_state_t;

    // Mask applied to primary-register writes for a given ROM size code.
    function automatic logic [PRIM_W-1:0] prim_mask(input logic [CODE_W-1:0] code);
        logic [PRIM_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRIM_W; i++) begin
            if (code >= CODE_W'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/bmap_cfg_latch.sv
// Configuration capture for the mapper.
// It samples the ROM size code and RAM size code on every clock while rst_n is low,
// and holds them while the block runs. ROM codes above the largest supported
// bank count are clamped. Assumes the configuration is stable during reset.
module bmap_cfg_latch
    import bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_rom_size,
    input  logic [1:0]        cfg_ram_size,
    output logic [CODE_W-1:0] rom_code,
    output ram_cfg_e          ram_cfg
);
    logic [CODE_W-1:0] rom_clamped;

    // Clamp out-of-range ROM codes to the largest bank count.
    always_comb begin
        rom_clamped = (cfg_rom_size > MAX_ROM_CODE) ? MAX_ROM_CODE : cfg_rom_size;
    end

    // Track configuration inputs only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_code <= rom_clamped;
            ram_cfg  <= ram_cfg_e'(cfg_ram_size);
        end
    end
endmodule

// File: rtl/bmap_ctrl_regs.sv
// Control register file of the mapper.
// It decodes CPU writes to the low 32 KB into RAM enable, primary bank,
// secondary bank and mode updates. The primary value is masked to the
// configured bank count when stored, and a zero value in bits 4:0 becomes 1.
// Assumes rom_code is stable outside reset.
module bmap_ctrl_regs
    import bank_mapper_pkg::*;
#(
    parameter logic [3:0] ENABLE_KEY = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rom_code,
    input  logic              ctl_wr,     // write into the control half this cycle
    input  ctl_sel_e          ctl_sel,
    input  logic [CTL_DW-1:0] ctl_data,
    output bank_state_t       st
);
    logic [PRIM_W-1:0] prim_next;

    // Next primary bank value: zero maps to one, otherwise size-masked.
    always_comb begin
        if (ctl_data[PRIM_W-1:0] == '0)
            prim_next = PRIM_W'(1);
        else
            prim_next = ctl_data[PRIM_W-1:0] & prim_mask(rom_code);
    end

    // Update the selected control register on a write, reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.ram_en <= 1'b0;
            st.mode   <= 1'b0;
            st.sec    <= '0;
            st.prim   <= PRIM_W'(1);
        end else if (ctl_wr) begin
            unique case (ctl_sel)
                CTL_ENABLE:    st.ram_en <= (ctl_data[3:0] == ENABLE_KEY);
                CTL_PRIMARY:   st.prim   <= prim_next;
                CTL_SECONDARY: st.sec    <= ctl_data[SEC_W-1:0];
                CTL_MODE:      st.mode   <= ctl_data[0];
                default:       st.mode   <= st.mode;
            endcase
        end
    end
endmodule

// File: rtl/bmap_rom_xlate.sv
// ROM address translation.
// It forms the 21-bit physical ROM address from the window select bit, the
// window offset and the bank registers. Bank bits above the primary field come
// from the secondary register only when the configured ROM has that many banks.
// In the fixed lower window they are used only in mode 1. Purely combinational.
module bmap_rom_xlate
    import bank_mapper_pkg::*;
(
    input  logic [CODE_W-1:0]    rom_code,
    input  bank_state_t          st,
    input  logic                 upper_win,
    input  logic [WIN_OFF_W-1:0] win_off,
    output logic [ROM_AW-1:0]    rom_addr
);
    logic [ROM_BANK_W-1:0] bank_hi;
    logic [ROM_BANK_W-1:0] bank_lo;

    // Build each bank bit: primary field, then size-gated secondary field.
    for (genvar k = 0; k < ROM_BANK_W; k++) begin : g_bank_bit
        if (k < PRIM_W) begin : g_prim
            assign bank_hi[k] = st.prim[k];
            assign bank_lo[k] = 1'b0;
        end else begin : g_ext
            logic present;
            assign present    = (rom_code >= CODE_W'(k));
            assign bank_hi[k] = present & st.sec[k-PRIM_W];
            assign bank_lo[k] = present & st.mode & st.sec[k-PRIM_W];
        end
    end

    // Select the window's bank and append the offset.
    always_comb begin
        rom_addr = {(upper_win ? bank_hi : bank_lo), win_off};
    end
endmodule

// File: rtl/bmap_ram_xlate.sv
// RAM address translation and access qualification.
// It maps an offset in the 8 KB RAM window onto the configured RAM size.
// On 32 KB parts in mode 1 the secondary register picks the page, and on
// 2 KB parts the offset wraps. It also qualifies the select with the window
// hit, the enable bit and the presence of a RAM. Purely combinational.
module bmap_ram_xlate
    import bank_mapper_pkg::*;
(
    input  ram_cfg_e              ram_cfg,
    input  bank_state_t           st,
    input  logic                  ram_win,
    input  logic [RAM_PAGE_W-1:0] page_off,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic                  ram_sel
);
    localparam int PAGE_PAD  = RAM_AW - RAM_PAGE_W;
    localparam int SMALL_PAD = RAM_AW - SMALL_RAM_W;

    // Map the window offset according to RAM size and mode.
    always_comb begin
        unique case (ram_cfg)
            RAM_32K: ram_addr = {(st.mode ? st.sec : {PAGE_PAD{1'b0}}), page_off};
            RAM_8K:  ram_addr = {{PAGE_PAD{1'b0}}, page_off};
            RAM_2K:  ram_addr = {{SMALL_PAD{1'b0}}, page_off[SMALL_RAM_W-1:0]};
            default: ram_addr = '0;
        endcase
    end

    // Access is valid only in the window, when enabled and when a RAM exists.
    always_comb begin
        ram_sel = ram_win & st.ram_en & (ram_cfg != RAM_NONE);
    end
endmodule

// File: rtl/bank_mapper.sv
// Two-mode banked ROM/RAM mapper, top level.
// It splits the CPU map into the ROM half, the RAM window and the unmapped
// rest. Writes to the ROM half go to the control registers. Reads are
// translated combinationally into ROM and RAM addresses, and the returned
// byte is picked from ROM, RAM or a 0xFF fill. Assumes the configuration
// inputs are stable while rst_n is low.
module bank_mapper
    import bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_rom_size,
    input  logic [1:0]        cfg_ram_size,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [20:0]       rom_addr,
    input  logic [7:0]        rom_rdata,
    output logic [14:0]       ram_addr,
    output logic              ram_sel,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata
);
    localparam logic [2:0] RAM_WIN_TAG = 3'b101;
    localparam logic [CPU_DW-1:0] FILL_BYTE = '1;

    logic [CODE_W-1:0] rom_code;
    ram_cfg_e          ram_cfg;
    bank_state_t       st;
    logic              rom_half;
    logic              ram_win;
    logic              ctl_wr;
    rd_src_e           rd_src;
    logic              wdata_unused;

    // Region decode of the CPU address.
    always_comb begin
        rom_half = ~bus_addr[CPU_AW-1];
        ram_win  = (bus_addr[CPU_AW-1:CPU_AW-3] == RAM_WIN_TAG);
        ctl_wr   = bus_wr & rom_half;
    end

    assign wdata_unused = ^bus_wdata[CPU_DW-1:CTL_DW];

    bmap_cfg_latch u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_rom_size (cfg_rom_size),
        .cfg_ram_size (cfg_ram_size),
        .rom_code     (rom_code),
        .ram_cfg      (ram_cfg)
    );

    bmap_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_code (rom_code),
        .ctl_wr   (ctl_wr),
        .ctl_sel  (ctl_sel_e'(bus_addr[CPU_AW-2:CPU_AW-3])),
        .ctl_data (bus_wdata[CTL_DW-1:0]),
        .st       (st)
    );

    bmap_rom_xlate u_rom (
        .rom_code  (rom_code),
        .st        (st),
        .upper_win (bus_addr[WIN_OFF_W]),
        .win_off   (bus_addr[WIN_OFF_W-1:0]),
        .rom_addr  (rom_addr)
    );

    bmap_ram_xlate u_ram (
        .ram_cfg  (ram_cfg),
        .st       (st),
        .ram_win  (ram_win),
        .page_off (bus_addr[RAM_PAGE_W-1:0]),
        .ram_addr (ram_addr),
        .ram_sel  (ram_sel)
    );

    // RAM writes pass only when the access is qualified.
    always_comb begin
        ram_we = bus_wr & ram_sel;
    end

    // Choose the source of the returned byte.
    always_comb begin
        if (rom_half)     rd_src = SRC_ROM;
        else if (ram_sel) rd_src = SRC_RAM;
        else              rd_src = SRC_FILL;
    end

    // Read data mux.
    always_comb begin
        unique case (rd_src)
            SRC_ROM: bus_rdata = rom_rdata;
            SRC_RAM: bus_rdata = ram_rdata;
            default: bus_rdata = FILL_BYTE;
        endcase
    end
endmodule

// File: rtl/bank_mapper_chk.sv
// Property checker for the banked mapper, attached by bind.
// It observes the bus, the translated outputs and the control register state.
module bank_mapper_chk
    import bank_mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic [20:0] rom_addr,
    input  logic        ram_sel,
    input  logic        ram_we,
    input  bank_state_t st
);
    p_enable_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:13] == 3'b000) |=> (st.ram_en == ($past(bus_wdata[3:0]) == 4'hA)));

    p_prim_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:13] == 3'b001 && bus_wdata[4:0] == 5'd0) |=> (st.prim == 5'd1));

    p_sec_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:13] == 3'b010) |=> (st.sec == $past(bus_wdata[1:0])));

    p_mode_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:13] == 3'b011) |=> (st.mode == $past(bus_wdata[0])));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(st));

    p_low_mode0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.mode && bus_addr[15:14] == 2'b00) |-> (rom_addr == {7'd0, bus_addr[13:0]}));

    p_closed_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:13] == 3'b101 && !st.ram_en) |-> (bus_rdata == 8'hFF && !ram_sel));

    p_we_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_sel && bus_wr && bus_addr[15:13] == 3'b101));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rom_addr  (rom_addr),
    .ram_sel   (ram_sel),
    .ram_we    (ram_we),
    .st        (st)
);

// File: tb/sim_bank_mapper.sv
// Sweep bench for the banked mapper: every ROM code and RAM code, full
// primary-register data sweep, all secondary/mode combinations.
`timescale 1ns/1ps
module sim_bank_mapper;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_rom_size = '0;
    logic [1:0]  cfg_ram_size = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [20:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [14:0] ram_addr;
    logic        ram_sel;
    logic        ram_we;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [20:0] a);
        return a[7:0] ^ a[20:13];
    endfunction
    function automatic logic [7:0] ram_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    assign rom_rdata = rom_byte(rom_addr);
    assign ram_rdata = ram_byte(ram_addr);

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rom_size(cfg_rom_size), .cfg_ram_size(cfg_ram_size),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_sel(ram_sel),
        .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    // Expected-value arithmetic from the requirements.
    function automatic int exp_prim(input int n, input int d);
        int m;
        if ((d % 32) == 0) return 1;
        m = (n >= 4) ? 31 : ((2 << n) - 1);
        return d & m;
    endfunction
    function automatic int exp_rom(input int n, input int p, input int s, input int m, input int a);
        int bank;
        if ((a & 16'h4000) != 0) begin
            bank = p;
            if (n == 5) bank = p + (s % 2) * 32;
            if (n == 6) bank = p + s * 32;
        end else begin
            bank = 0;
            if (m == 1 && n == 5) bank = (s % 2) * 32;
            if (m == 1 && n == 6) bank = s * 32;
        end
        return bank * 16384 + (a & 16'h3FFF);
    endfunction
    function automatic int exp_ram(input int r, input int m, input int s, input int off);
        if (r == 3) return (m == 1) ? s * 8192 + off : off;
        if (r == 2) return off;
        return off % 2048;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
    endtask

    task automatic do_reset(input int n, input int r);
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        cfg_rom_size = 3'(n); cfg_ram_size = 2'(r);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R8: configuration changes after reset must be ignored
        cfg_rom_size = 3'(6 - n); cfg_ram_size = ~2'(r);
    endtask

    initial begin
        int p;
        repeat (2) @(negedge clk);
        for (int n = 0; n < 7; n++) begin
            for (int r = 0; r < 4; r++) begin
                do_reset(n, r);
                // R8 reset state
                look(16'h4000); chk("R8 reset upper bank", 32'(rom_addr), 32'h4000);
                look(16'h0123); chk("R8 reset lower bank", 32'(rom_addr), 32'h0123);
                look(16'hA000); chk("R8 reset ram disabled sel", 32'(ram_sel), 0);
                chk("R8 reset ram fill", 32'(bus_rdata), 32'hFF);

                // R2/R5 primary sweep
                for (int d = 0; d < 256; d++) begin
                    int a;
                    wr((d % 2 == 0) ? 16'h2000 : 16'h3FFF, 8'(d));
                    a = 16'h4000 + ((d * 53) & 16'h3FFF);
                    look(16'(a));
                    chk("R2 R5 primary bank", 32'(rom_addr), 32'(exp_rom(n, exp_prim(n, d), 0, 0, a)));
                    if (d % 16 == 0)
                        chk("R9 rom data", 32'(bus_rdata), 32'(rom_byte(21'(exp_rom(n, exp_prim(n, d), 0, 0, a)))));
                end
                p = exp_prim(n, 255);

                // R10 control write does not strobe ram
                @(negedge clk);
                bus_addr = 16'h2100; bus_wdata = 8'hFF; bus_wr = 1'b1; #1;
                chk("R10 control write no ram_we", 32'(ram_we), 0);
                @(negedge clk); bus_wr = 1'b0;

                wr(16'h0000, 8'h5A); // enable RAM, upper nibble ignored
                for (int s = 0; s < 4; s++) begin
                    for (int m = 0; m < 2; m++) begin
                        wr(16'h4000, {6'b101101, 2'(s)});
                        wr(16'h6000, 8'hA4 | 8'(m));
                        look(16'h7FFF);
                        chk("R5 upper with secondary", 32'(rom_addr), 32'(exp_rom(n, p, s, m, 16'h7FFF)));
                        look(16'h3ABC);
                        chk("R4 lower window", 32'(rom_addr), 32'(exp_rom(n, p, s, m, 16'h3ABC)));
                        chk("R9 lower rom data", 32'(bus_rdata), 32'(rom_byte(21'(exp_rom(n, p, s, m, 16'h3ABC)))));
                        for (int k = 0; k < 5; k++) begin
                            int off;
                            int ea;
                            off = (k == 0) ? 0 : (k == 1) ? 16'h07FF : (k == 2) ? 16'h0800 : (k == 3) ? 16'h1FFF : 16'h1234;
                            ea = exp_ram(r, m, s, off);
                            look(16'hA000 + 16'(off));
                            chk("R10 ram_sel", 32'(ram_sel), (r != 0) ? 1 : 0);
                            if (r != 0) begin
                                chk("R6 ram address", 32'(ram_addr), 32'(ea));
                                chk("R9 ram data", 32'(bus_rdata), 32'(ram_byte(15'(ea))));
                            end else begin
                                chk("R7 no ram fill", 32'(bus_rdata), 32'hFF);
                            end
                        end
                        look(16'hC000); chk("R7 unmapped fill", 32'(bus_rdata), 32'hFF);
                        look(16'h9FFF); chk("R7 unmapped fill low", 32'(bus_rdata), 32'hFF);
                    end
                end

                // R5/R3 coincident write to secondary inside the upper window
                @(negedge clk);
                bus_addr = 16'h5ABC; bus_wdata = 8'h01; bus_wr = 1'b1; #1;
                chk("R5 old bank during write", 32'(rom_addr), 32'(exp_rom(n, p, 3, 1, 16'h5ABC)));
                @(negedge clk); bus_wr = 1'b0; #1;
                chk("R3 R5 new bank after write", 32'(rom_addr), 32'(exp_rom(n, p, 1, 1, 16'h5ABC)));

                // R1 enable nibble sweep with R7/R10 probes
                for (int v = 0; v < 16; v++) begin
                    logic en;
                    en = (v == 10) && (r != 0);
                    wr(16'h1000 + 16'(v), 8'((v ^ 5) << 4) | 8'(v));
                    look(16'hA100);
                    chk("R1 enable nibble sel", 32'(ram_sel), en ? 1 : 0);
                    if (!en) chk("R7 disabled fill", 32'(bus_rdata), 32'hFF);
                    @(negedge clk);
                    bus_addr = 16'hB000; bus_wdata = 8'h33; bus_wr = 1'b1; #1;
                    chk("R10 ram_we follows enable", 32'(ram_we), en ? 1 : 0);
                    @(negedge clk); bus_wr = 1'b0;
                end
            end
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule